// File: doc/BRIEF.md
# Privileged Stack Pointer Fetch Unit

This block supplies the stack segment selector and stack pointer that a privilege change needs, taken from the task-state segment of the running task. A request names a target privilege level from 0 to 2. The block also receives the type, base and limit of the task-register descriptor and the task-register selector. It works out the location of the stack pair inside the segment and checks that location against the segment limit. It then fetches the two values one at a time over a simple read port with a request/acknowledge handshake.

The same engine also returns the back-link selector, which is the word at the segment base. A request that would run past the segment limit does not reach memory. Such a request ends in an invalid-segment fault and carries an error code. A request that names an unknown descriptor type, or privilege level 3, ends in an internal-error pulse. Descriptor parsing and the memory system are outside the block.

Top module: `tss_stack_fetch`

## Requirements
- R1: After reset, `done`, `fault`, `int_err` and `mem_req` are low, and `stack_sel`, `stack_ptr` and `fault_code` are zero.
- R2: For the 32-bit busy type (`tss_type` = 4'hB), the offset is level×8+4. The block reads a doubleword (`mem_dword`=1) at base+offset, which becomes `stack_ptr`. It then reads a word (`mem_dword`=0) at base+offset+4, whose bits [15:0] become `stack_sel`.
- R3: For the 16-bit busy type (`tss_type` = 4'h3), the offset is level×4+2. The block reads a word at base+offset, whose bits [15:0] become `stack_ptr` with the upper 16 bits cleared. It then reads a word at base+offset+2, which becomes `stack_sel`.
- R4: A 32-bit stack request faults when offset+7 > limit. When offset+7 equals the limit, the request is served.
- R5: A 16-bit stack request faults when offset+3 > limit. When offset+3 equals the limit, the request is served.
- R6: A fault is a one-cycle `fault` pulse in the cycle after the request is sampled. `fault_code` then equals `tr_sel` with bits [1:0] cleared, and no memory read is issued.
- R7: A back-link request (`req_backlink`=1) makes one word read at the segment base and returns the word on `stack_sel`, leaving `stack_ptr` unchanged. It faults when the limit is below 4 for the 32-bit type, or below 2 for the 16-bit type. The level is ignored.
- R8: Any other `tss_type` gives a one-cycle `int_err` pulse in the cycle after the request, with no memory read.
- R9: A stack request at level 3 gives a one-cycle `int_err` pulse in the cycle after the request, with no memory read.
- R10: `mem_req` stays high with a stable address and width until `mem_ack` is sampled high. Only one read is outstanding at a time. `done` is high for exactly one cycle, the cycle after the last acknowledge.
- R11: `req_valid` is ignored while a read sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_backlink | input | 1 | 1: back-link read, 0: stack pair fetch |
| req_level | input | 2 | Target privilege level |
| tss_type | input | 4 | Task-register descriptor type |
| seg_base | input | 32 | Task segment base address |
| seg_limit | input | 32 | Task segment limit |
| tr_sel | input | 16 | Task-register selector |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | 32 | Read byte address |
| mem_dword | output | 1 | 1: doubleword read, 0: word read |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data, word reads use bits [15:0] |
| done | output | 1 | One-cycle completion pulse |
| stack_sel | output | 16 | Fetched stack selector or back-link |
| stack_ptr | output | 32 | Fetched stack pointer |
| fault | output | 1 | One-cycle invalid-segment fault pulse |
| fault_code | output | 16 | Fault error code |
| int_err | output | 1 | One-cycle internal-error pulse |

## Verification
A rejected request, whether by fault or internal error, shows its pulse exactly one cycle after the request edge. A served request shows `done` after 1 + reads×(latency+1) cycles. Here latency is the number of idle cycles the bench's memory responder inserts before each acknowledge. Each scenario task counts falling edges from the request and compares the count with that figure. It reads the outcome outputs only on falling edges. It also logs every address and width that the responder accepted, so the absence of reads and the order of reads are checked at the port.

// File: rtl/tss_sp_pkg.sv
package tss_sp_pkg;
  localparam logic [3:0] TYPE_BUSY32 = 4'hB;
  localparam logic [3:0] TYPE_BUSY16 = 4'h3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_PTR = 2'd1,
    ST_RD_SEL = 2'd2
  } seq_state_e;
endpackage

// File: rtl/tss_sp_decode.sv
module tss_sp_decode
  import tss_sp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              is_bl,
  input  logic [1:0]        lvl,
  input  logic [3:0]        tss_type,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  output logic              illegal,
  output logic              lim_fail,
  output logic              first_dw,
  output logic [ADDR_W-1:0] addr_a,
  output logic [ADDR_W-1:0] addr_b
);
  logic              is32;
  logic              is16;
  logic [ADDR_W-1:0] lvl_w;
  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] last;
  logic [ADDR_W-1:0] step;

  always_comb begin
    is32  = (tss_type == TYPE_BUSY32);
    is16  = (tss_type == TYPE_BUSY16);
    lvl_w = ADDR_W'(lvl);
    // stack pair location and last byte touched, per format
    if (is32) begin
      off  = (lvl_w << 3) + ADDR_W'(4);
      last = off + ADDR_W'(7);
      step = ADDR_W'(4);
    end else begin
      off  = (lvl_w << 2) + ADDR_W'(2);
      last = off + ADDR_W'(3);
      step = ADDR_W'(2);
    end
    illegal = !(is32 || is16) || (!is_bl && (lvl == 2'd3));
    if (is_bl) begin
      lim_fail = is32 ? (limit < ADDR_W'(4)) : (limit < ADDR_W'(2));
      addr_a   = base;
      addr_b   = base;
      first_dw = 1'b0;
    end else begin
      lim_fail = (last > limit);
      addr_a   = base + off;
      addr_b   = base + off + step;
      first_dw = is32;
    end
  end
endmodule

// File: rtl/tss_sp_seq.sv
module tss_sp_seq
  import tss_sp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_bl,
  input  logic              illegal,
  input  logic              lim_fail,
  input  logic              first_dw,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [SEL_W-1:0]  tr_sel,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_dword,
  output logic              cap_ptr,
  output logic              cap_sel,
  output logic              done,
  output logic              fault,
  output logic [SEL_W-1:0]  fault_code,
  output logic              int_err
);
  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] addr2_q, addr2_d;
  logic              dw_q, dw_d;
  logic              bl_q, bl_d;
  logic              done_q, done_d;
  logic              fault_q, fault_d;
  logic              ierr_q, ierr_d;
  logic [SEL_W-1:0]  code_q, code_d;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    addr2_d = addr2_q;
    dw_d    = dw_q;
    bl_d    = bl_q;
    done_d  = 1'b0;
    fault_d = 1'b0;
    ierr_d  = 1'b0;
    code_d  = code_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (illegal) begin
            ierr_d = 1'b1;
          end else if (lim_fail) begin
            fault_d = 1'b1;
            code_d  = tr_sel & ~SEL_W'(3);
          end else begin
            state_d = ST_RD_PTR;
            addr_d  = addr_a;
            addr2_d = addr_b;
            dw_d    = first_dw;
            bl_d    = req_bl;
          end
        end
      end
      ST_RD_PTR: begin
        if (mem_ack) begin
          if (bl_q) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_RD_SEL;
            addr_d  = addr2_q;
            dw_d    = 1'b0;
          end
        end
      end
      ST_RD_SEL: begin
        if (mem_ack) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      addr2_q <= '0;
      dw_q    <= 1'b0;
      bl_q    <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      ierr_q  <= 1'b0;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      addr2_q <= addr2_d;
      dw_q    <= dw_d;
      bl_q    <= bl_d;
      done_q  <= done_d;
      fault_q <= fault_d;
      ierr_q  <= ierr_d;
      if (fault_d) begin
        code_q <= code_d;
      end
    end
  end

  assign mem_req    = (state_q != ST_IDLE);
  assign mem_addr   = addr_q;
  assign mem_dword  = dw_q;
  assign cap_ptr    = (state_q == ST_RD_PTR) && mem_ack && !bl_q;
  assign cap_sel    = ((state_q == ST_RD_PTR) && mem_ack && bl_q) ||
                      ((state_q == ST_RD_SEL) && mem_ack);
  assign done       = done_q;
  assign fault      = fault_q;
  assign fault_code = code_q;
  assign int_err    = ierr_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_dword))); // R10
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_ack)); // R10
  AST_FAULT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ($past(req_valid) && !mem_req)); // R6
  AST_INTERR_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    int_err |-> ($past(req_valid) && !mem_req)); // R8
endmodule

// File: rtl/tss_sp_result.sv
module tss_sp_result #(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_ptr,
  input  logic              cap_sel,
  input  logic              dword,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ptr,
  output logic [SEL_W-1:0]  sel
);
  localparam int PAD_W = DATA_W - SEL_W;

  logic [DATA_W-1:0] ptr_q, ptr_d;
  logic [SEL_W-1:0]  sel_q, sel_d;

  always_comb begin
    ptr_d = dword ? rdata : {{PAD_W{1'b0}}, rdata[SEL_W-1:0]};
    sel_d = rdata[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      sel_q <= '0;
    end else begin
      if (cap_ptr) ptr_q <= ptr_d;
      if (cap_sel) sel_q <= sel_d;
    end
  end

  assign ptr = ptr_q;
  assign sel = sel_q;

  AST_PTR16_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ptr && !dword) |=> (ptr[DATA_W-1:SEL_W] == '0)); // R3
endmodule

// File: rtl/tss_stack_fetch.sv
module tss_stack_fetch #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SEL_W  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_backlink,
  input  logic [1:0]        req_level,
  input  logic [3:0]        tss_type,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic [SEL_W-1:0]  tr_sel,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_dword,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic [SEL_W-1:0]  stack_sel,
  output logic [DATA_W-1:0] stack_ptr,
  output logic              fault,
  output logic [SEL_W-1:0]  fault_code,
  output logic              int_err
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n_s;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_s = rst_pipe[SYNC_STAGES-1];

  logic              illegal, lim_fail, first_dw;
  logic [ADDR_W-1:0] addr_a, addr_b;
  logic              cap_ptr, cap_sel;

  tss_sp_decode #(.ADDR_W(ADDR_W)) u_decode (
    .is_bl    (req_backlink),
    .lvl      (req_level),
    .tss_type (tss_type),
    .base     (seg_base),
    .limit    (seg_limit),
    .illegal  (illegal),
    .lim_fail (lim_fail),
    .first_dw (first_dw),
    .addr_a   (addr_a),
    .addr_b   (addr_b)
  );

  tss_sp_seq #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .req_valid  (req_valid),
    .req_bl     (req_backlink),
    .illegal    (illegal),
    .lim_fail   (lim_fail),
    .first_dw   (first_dw),
    .addr_a     (addr_a),
    .addr_b     (addr_b),
    .tr_sel     (tr_sel),
    .mem_ack    (mem_ack),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_dword  (mem_dword),
    .cap_ptr    (cap_ptr),
    .cap_sel    (cap_sel),
    .done       (done),
    .fault      (fault),
    .fault_code (fault_code),
    .int_err    (int_err)
  );

  tss_sp_result #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_result (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .cap_ptr (cap_ptr),
    .cap_sel (cap_sel),
    .dword   (mem_dword),
    .rdata   (mem_rdata),
    .ptr     (stack_ptr),
    .sel     (stack_sel)
  );
endmodule

// File: tb/tss_stack_fetch_bench.sv
`timescale 1ns/1ps
module tss_stack_fetch_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_backlink;
  logic [1:0]  req_level;
  logic [3:0]  tss_type;
  logic [31:0] seg_base, seg_limit;
  logic [15:0] tr_sel;
  logic        mem_req, mem_dword, mem_ack;
  logic [31:0] mem_addr, mem_rdata;
  logic        done, fault, int_err;
  logic [15:0] stack_sel, fault_code;
  logic [31:0] stack_ptr;

  int tests = 0;
  int failed = 0;
  int lat_cfg = 0;
  int rd_cnt = 0;
  logic [31:0] rd_addr [0:7];
  logic        rd_dw   [0:7];
  int outcome;
  int cycles;

  localparam logic [3:0] T32 = 4'hB;
  localparam logic [3:0] T16 = 4'h3;

  always #4 clk = ~clk;

  tss_stack_fetch u_tss_stack_fetch (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_backlink(req_backlink),
    .req_level(req_level), .tss_type(tss_type), .seg_base(seg_base),
    .seg_limit(seg_limit), .tr_sel(tr_sel), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_dword(mem_dword), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done),
    .stack_sel(stack_sel), .stack_ptr(stack_ptr), .fault(fault),
    .fault_code(fault_code), .int_err(int_err)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {~a[15:0], a[15:0] ^ 16'h3C5A};
  endfunction

  // memory responder: acknowledges after lat_cfg idle cycles
  initial begin
    int cnt;
    cnt = 0;
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        if (cnt >= lat_cfg) begin
          mem_ack = 1'b1;
          mem_rdata = pat(mem_addr);
          if (rd_cnt < 8) begin
            rd_addr[rd_cnt] = mem_addr;
            rd_dw[rd_cnt] = mem_dword;
          end
          rd_cnt++;
          cnt = 0;
        end else begin
          mem_ack = 1'b0;
          cnt++;
        end
      end else begin
        mem_ack = 1'b0;
        cnt = 0;
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  // outcome: 0 none, 1 done, 2 fault, 3 int_err
  task automatic launch(input logic bl, input logic [1:0] lvl, input logic [3:0] typ,
                        input logic [31:0] base, input logic [31:0] lim,
                        input logic [15:0] sel, input int lat);
    @(negedge clk);
    rd_cnt = 0;
    lat_cfg = lat;
    req_backlink = bl; req_level = lvl; tss_type = typ;
    seg_base = base; seg_limit = lim; tr_sel = sel;
    req_valid = 1'b1;
    outcome = 0;
    cycles = 0;
    for (int k = 1; k <= 64 && outcome == 0; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (done)         begin outcome = 1; cycles = k; end
      else if (fault)   begin outcome = 2; cycles = k; end
      else if (int_err) begin outcome = 3; cycles = k; end
    end
  endtask

  task automatic stack_case(input logic [3:0] typ, input logic [1:0] lvl,
                            input logic [31:0] base, input logic [31:0] lim, input int lat);
    logic        is32;
    logic [31:0] off, a0, a1, p0, p1;
    string       r;
    is32 = (typ == T32);
    r = is32 ? "R2" : "R3";
    off = is32 ? 32'(lvl) * 8 + 4 : 32'(lvl) * 4 + 2;
    a0 = base + off;
    a1 = a0 + (is32 ? 32'd4 : 32'd2);
    p0 = pat(a0);
    p1 = pat(a1);
    launch(1'b0, lvl, typ, base, lim, 16'h1237, lat);
    chk({r, " outcome done"}, 32'(outcome), 32'd1);
    chk("R10 done latency", 32'(cycles), 32'(1 + 2 * (lat + 1)));
    chk({r, " read count"}, 32'(rd_cnt), 32'd2);
    chk({r, " first addr"}, rd_addr[0], a0);
    chk({r, " first width"}, 32'(rd_dw[0]), 32'(is32));
    chk({r, " second addr"}, rd_addr[1], a1);
    chk({r, " second width"}, 32'(rd_dw[1]), 32'd0);
    chk({r, " pointer"}, stack_ptr, is32 ? p0 : {16'h0, p0[15:0]});
    chk({r, " selector"}, 32'(stack_sel), 32'(p1[15:0]));
    @(negedge clk);
    chk("R10 done one cycle", 32'(done), 32'd0);
  endtask

  task automatic fault_case(input string r, input logic bl, input logic [3:0] typ,
                            input logic [1:0] lvl, input logic [31:0] lim, input logic [15:0] sel);
    launch(bl, lvl, typ, 32'h0004_1000, lim, sel, 0);
    chk({r, " fault outcome"}, 32'(outcome), 32'd2);
    chk("R6 fault latency", 32'(cycles), 32'd1);
    chk("R6 no read", 32'(rd_cnt), 32'd0);
    chk("R6 fault code", 32'(fault_code), 32'(sel & 16'hFFFC));
    @(negedge clk);
    chk("R6 fault one cycle", 32'(fault), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 fault", 32'(fault), 32'd0);
    chk("R1 int_err", 32'(int_err), 32'd0);
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    chk("R1 stack_sel", 32'(stack_sel), 32'd0);
    chk("R1 stack_ptr", stack_ptr, 32'd0);
    chk("R1 fault_code", 32'(fault_code), 32'd0);
  endtask

  task automatic t_stack32;
    stack_case(T32, 2'd0, 32'h0010_0000, 32'h67, 0);
    stack_case(T32, 2'd2, 32'h0020_8000, 32'h67, 2);
  endtask

  task automatic t_stack16;
    stack_case(T16, 2'd1, 32'h0000_9A00, 32'h2B, 0);
    stack_case(T16, 2'd0, 32'h0003_0010, 32'h2B, 1);
  endtask

  task automatic t_limit32;
    stack_case(T32, 2'd1, 32'h0005_0000, 32'd19, 0); // R4 boundary served
    fault_case("R4", 1'b0, T32, 2'd1, 32'd18, 16'h004B);
  endtask

  task automatic t_limit16;
    stack_case(T16, 2'd2, 32'h0006_0000, 32'd13, 0); // R5 boundary served
    fault_case("R5", 1'b0, T16, 2'd2, 32'd12, 16'hFFFF);
  endtask

  task automatic t_backlink;
    logic [31:0] prev_ptr, p;
    stack_case(T32, 2'd0, 32'h0007_0000, 32'h67, 0);
    prev_ptr = stack_ptr;
    launch(1'b1, 2'd3, T32, 32'h0008_0040, 32'd4, 16'h0010, 1);
    p = pat(32'h0008_0040);
    chk("R7 outcome", 32'(outcome), 32'd1);
    chk("R7 latency", 32'(cycles), 32'd3);
    chk("R7 read count", 32'(rd_cnt), 32'd1);
    chk("R7 address", rd_addr[0], 32'h0008_0040);
    chk("R7 width", 32'(rd_dw[0]), 32'd0);
    chk("R7 selector", 32'(stack_sel), 32'(p[15:0]));
    chk("R7 pointer kept", stack_ptr, prev_ptr);
    launch(1'b1, 2'd0, T16, 32'h0008_0100, 32'd2, 16'h0010, 0);
    p = pat(32'h0008_0100);
    chk("R7 16-bit outcome", 32'(outcome), 32'd1);
    chk("R7 16-bit selector", 32'(stack_sel), 32'(p[15:0]));
    fault_case("R7", 1'b1, T32, 2'd0, 32'd3, 16'h0023);
    fault_case("R7", 1'b1, T16, 2'd0, 32'd1, 16'h0036);
  endtask

  task automatic t_bad_type;
    launch(1'b0, 2'd0, 4'h9, 32'h0001_0000, 32'h67, 16'h0008, 0);
    chk("R8 outcome", 32'(outcome), 32'd3);
    chk("R8 latency", 32'(cycles), 32'd1);
    chk("R8 no read", 32'(rd_cnt), 32'd0);
    launch(1'b1, 2'd0, 4'h1, 32'h0001_0000, 32'h67, 16'h0008, 0);
    chk("R8 backlink outcome", 32'(outcome), 32'd3);
    chk("R8 backlink no read", 32'(rd_cnt), 32'd0);
  endtask

  task automatic t_level3;
    launch(1'b0, 2'd3, T32, 32'h0001_0000, 32'h67, 16'h0008, 0);
    chk("R9 outcome", 32'(outcome), 32'd3);
    chk("R9 latency", 32'(cycles), 32'd1);
    chk("R9 no read", 32'(rd_cnt), 32'd0);
    launch(1'b0, 2'd3, T16, 32'h0001_0000, 32'h2B, 16'h0008, 0);
    chk("R9 16-bit outcome", 32'(outcome), 32'd3);
    chk("R9 16-bit no read", 32'(rd_cnt), 32'd0);
  endtask

  task automatic t_busy_ignore;
    int hits;
    @(negedge clk);
    rd_cnt = 0;
    lat_cfg = 3;
    req_backlink = 1'b0; req_level = 2'd1; tss_type = T32;
    seg_base = 32'h000A_0000; seg_limit = 32'h67; tr_sel = 16'h0008;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_backlink = 1'b1; seg_base = 32'h000B_0000; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    hits = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (done || fault || int_err) hits++;
    end
    chk("R11 single outcome", 32'(hits), 32'd1);
    chk("R11 read count", 32'(rd_cnt), 32'd2);
    chk("R11 first addr", rd_addr[0], 32'h000A_000C);
    chk("R11 second addr", rd_addr[1], 32'h000A_0010);
    chk("R11 pointer", stack_ptr, pat(32'h000A_000C));
    chk("R11 idle after", 32'(mem_req), 32'd0);
  endtask

  initial begin
    #(8 * 100000);
    failed++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_backlink = 1'b0; req_level = '0; tss_type = '0;
    seg_base = '0; seg_limit = '0; tr_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_stack32();
    t_stack16();
    t_limit32();
    t_limit16();
    t_backlink();
    t_bad_type();
    t_level3();
    t_busy_ignore();
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule